// File: doc/BRIEF.md
# Function Unit with Status Flags

This block is the combinational arithmetic, logic and shift stage of a small register-file processor. Two data words, A and B, enter together with a 4-bit function select. The unit returns one result word and four status flags: negative, zero, carry and overflow. Everything settles within the same cycle. Operand selection, the register file, memory and sequencing all sit outside the block.

All arithmetic functions share a single adder. The second adder input is zero, B, the complement of B, or an all-ones word, and the function code picks the carry-in. This is how increment, addition, subtraction and decrement all reach the same carry chain. The logic functions work bit by bit. The move and shift functions act on B, and a shift moves it by one position. The data width is a parameter with a default of 8 bits.

Top module: `alu_flags`

## Requirements
- R1: Function code 0000 returns A unchanged. Code 0001 returns A+1, and code 0010 returns A+B, both modulo 2^W.
- R2: Code 0101 returns A−B, formed as A + ~B + 1. Code 0110 returns A−1, formed as A plus an all-ones word.
- R3: Codes 1000, 1001 and 1010 return A AND B, A OR B and A XOR B. Code 1011 returns ~A.
- R4: Code 1100 returns B unchanged. Code 1101 returns B shifted right by one with 0 entering at the MSB. Code 1110 returns B shifted left by one with 0 entering at the LSB.
- R5: Codes 0011, 0100, 0111 and 1111 return an all-zero result.
- R6: Flag n equals the MSB of the result, and z is 1 exactly when every result bit is 0. Both hold for every code.
- R7: For codes 0000, 0001, 0010, 0101 and 0110, c is the carry out of the adder's top bit. For subtraction, c=1 means that no borrow occurred.
- R8: For the adder codes, v is 1 exactly when both adder inputs have the same sign and the sum has the opposite sign.
- R9: For every code other than the five adder codes, c and v are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fsel | input | 4 | Function select code |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| y | output | W | Result |
| n | output | 1 | Negative flag (result MSB) |
| z | output | 1 | Zero flag |
| c | output | 1 | Adder carry out |
| v | output | 1 | Signed overflow flag |

## Verification
The block holds no state, so a defect shows at the ports in the same evaluation as the code that triggers it. A wrong addend or carry-in choice corrupts only the result and flags of the adder function it belongs to. The checks therefore cover every code, including the sign-boundary operands 0x7F, 0x80, 0x00 and 0xFF. A flag that leaks into a non-adder function shows up as a nonzero c or v on a logic, move or shift code.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 8
) (
  input  logic [3:0]   fsel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] y,
  output logic         n,
  output logic         z,
  output logic         c,
  output logic         v
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] addend;
  logic         cin;
  logic         is_arith;
  logic [W:0]   sum;

  always_comb begin
    addend   = '0;
    cin      = 1'b0;
    is_arith = 1'b1;
    case (fsel)
      4'b0000: ;
      4'b0001: cin = 1'b1;
      4'b0010: addend = b_in;
      4'b0101: begin addend = ~b_in; cin = 1'b1; end
      4'b0110: addend = '1;
      default: is_arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, a_in} + {1'b0, addend} + {{W{1'b0}}, cin};

  always_comb begin
    case (fsel)
      4'b0000, 4'b0001, 4'b0010,
      4'b0101, 4'b0110: y = sum[W-1:0];
      4'b1000: y = a_in & b_in;
      4'b1001: y = a_in | b_in;
      4'b1010: y = a_in ^ b_in;
      4'b1011: y = ~a_in;
      4'b1100: y = b_in;
      4'b1101: y = {1'b0, b_in[W-1:1]};
      4'b1110: y = {b_in[W-2:0], 1'b0};
      default: y = '0;
    endcase
  end

  assign n = y[W-1];
  assign z = (y == '0);
  assign c = is_arith & sum[W];
  assign v = is_arith & (a_in[W-1] == addend[W-1]) & (sum[W-1] != a_in[W-1]);

  always_comb begin
    // R2
    if (fsel == 4'b0101) sub_inverse_chk: assert (W'(y + b_in) == a_in);
    // R2
    if (fsel == 4'b0110) dec_inverse_chk: assert (W'(y + ONE) == a_in);
    // R9
    if (fsel[3]) no_overflow_chk: assert (!c && !v);
    // R5
    if (fsel == 4'b0011 || fsel == 4'b0100 || fsel == 4'b0111 || fsel == 4'b1111)
      unused_zero_chk: assert (z && !n);
    // R6
    flag_excl_chk: assert (!(z && n));
    // R4
    if (fsel == 4'b1101) shr_fill_chk: assert (!n);
    // R4
    if (fsel == 4'b1110) shl_fill_chk: assert (!y[0]);
    // R1
    if (fsel == 4'b0000) pass_a_chk: assert (y == a_in && !c && !v);
  end
endmodule

// File: tb/tb_alu_flags.sv
module tb_alu_flags;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]   fsel;
  logic [W-1:0] a_in, b_in, y;
  logic         n, z, c, v;

  alu_flags #(.W(W)) dut (.fsel(fsel), .a_in(a_in), .b_in(b_in),
                          .y(y), .n(n), .z(z), .c(c), .v(v));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [W+3:0] model(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0]   s;
    logic [W-1:0] r, addv;
    logic         cf, vf, ar;
    ar = 1'b1; addv = '0; s = '0;
    case (f)
      4'b0000: begin addv = '0;  s = {1'b0, a}; end
      4'b0001: begin addv = '0;  s = {1'b0, a} + 1; end
      4'b0010: begin addv = b;   s = {1'b0, a} + {1'b0, b}; end
      4'b0101: begin addv = ~b;  s = {1'b0, a} + {1'b0, ~b} + 1; end
      4'b0110: begin addv = '1;  s = {1'b0, a} + {1'b0, {W{1'b1}}}; end
      default: ar = 1'b0;
    endcase
    case (f)
      4'b1000: r = a & b;
      4'b1001: r = a | b;
      4'b1010: r = a ^ b;
      4'b1011: r = ~a;
      4'b1100: r = b;
      4'b1101: r = b >> 1;
      4'b1110: r = b << 1;
      default: r = ar ? s[W-1:0] : '0;
    endcase
    cf = ar && s[W];
    vf = ar && (a[W-1] == addv[W-1]) && (s[W-1] != a[W-1]);
    return {r[W-1], (r == '0), cf, vf, r};
  endfunction

  function automatic string tag(input logic [3:0] f);
    case (f)
      4'b0000, 4'b0001, 4'b0010: return "R1";
      4'b0101, 4'b0110:          return "R2";
      4'b1000, 4'b1001, 4'b1010, 4'b1011: return "R3";
      4'b1100, 4'b1101, 4'b1110: return "R4";
      default:                   return "R5";
    endcase
  endfunction

  task automatic apply(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W+3:0] e;
    @(negedge clk);
    fsel = f; a_in = a; b_in = b;
    #1;
    e = model(f, a, b);
    checks++;
    if (y !== e[W-1:0]) begin
      errors++;
      $display("FAIL %s result f=%b a=%h b=%h actual=%h expected=%h", tag(f), f, a, b, y, e[W-1:0]);
    end
    checks++;
    if ({n, z} !== e[W+3:W+2]) begin
      errors++;
      $display("FAIL R6 nz f=%b a=%h b=%h actual=%b expected=%b", f, a, b, {n, z}, e[W+3:W+2]);
    end
    checks++;
    if (c !== e[W+1]) begin
      errors++;
      $display("FAIL %s carry f=%b a=%h b=%h actual=%b expected=%b", (f[3] ? "R9" : "R7"), f, a, b, c, e[W+1]);
    end
    checks++;
    if (v !== e[W]) begin
      errors++;
      $display("FAIL %s overflow f=%b a=%h b=%h actual=%b expected=%b", (f[3] ? "R9" : "R8"), f, a, b, v, e[W]);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corner [6];
    void'($urandom(32'h5eed_1234));
    corner[0] = 8'h00; corner[1] = 8'h01; corner[2] = 8'h7F;
    corner[3] = 8'h80; corner[4] = 8'hFF; corner[5] = 8'hA5;
    fsel = '0; a_in = '0; b_in = '0;
    // R1 pass A, zero result flags (R6)
    apply(4'b0000, 8'h00, 8'h33);
    // R1, R8 increment across the sign boundary sets overflow
    apply(4'b0001, 8'h7F, 8'h00);
    // R1, R7 increment wraps with carry
    apply(4'b0001, 8'hFF, 8'h00);
    // R8 add of two negatives overflows
    apply(4'b0010, 8'h80, 8'h80);
    // R2, R7 equal subtract: zero, no borrow
    apply(4'b0101, 8'h42, 8'h42);
    // R2 borrow case
    apply(4'b0101, 8'h00, 8'h01);
    // R2, R8 decrement of most negative overflows
    apply(4'b0110, 8'h80, 8'h00);
    // R2 decrement of zero: no carry
    apply(4'b0110, 8'h00, 8'h00);
    // R4 shifts fill with zero
    apply(4'b1101, 8'h00, 8'hFF);
    apply(4'b1110, 8'h00, 8'hFF);
    // R5 unused codes
    apply(4'b0011, 8'hFF, 8'hFF);
    apply(4'b0100, 8'h12, 8'h34);
    apply(4'b0111, 8'h80, 8'h7F);
    apply(4'b1111, 8'hFF, 8'h01);
    // R3, R9 every code over all corner pairs
    for (int f = 0; f < 16; f++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(4'(f), corner[i], corner[j]);
    for (int k = 0; k < 3000; k++)
      apply(4'($urandom_range(15)), 8'($urandom), 8'($urandom));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule